// File: doc/BRIEF.md
# Quad 12-bit DAC Code Register Bank

This block sits between a byte-wide host register bus and four 12-bit digital-to-analog converter channels. Because a 12-bit code does not fit in one bus byte, each code is delivered in two accesses. First the low eight bits go into a staging register that every channel shares. Then the top four bits are written to the address that belongs to the target channel. That second write joins the high nibble to the staged byte and parks the full code in the channel's pending latch.

The converters never see a pending value directly. A read access to any channel address acts as an update strobe. On that single clock edge every pending latch is copied to its output latch, so several channels can be loaded one by one and then change together. A channel that got no new code since the last update keeps driving the same value, because its pending latch still holds that value.

The largest code is 4095, so the output never reaches full scale. The outputs leave the block as one flat vector, with channel k in bits [12k+11:12k].

Top module: `dac_quad_latch`

## Requirements
- R1: A synchronous reset clears the staging register, all four pending latches and all four output latches to zero. An update after reset therefore drives zero, and a high write after reset with no prior low write loads a code whose bits 7:0 are zero.
- R2: A write to offset 1 stores the byte in the shared staging register. The register keeps that byte until the next write to offset 1, so one staged byte can feed high writes to several channels.
- R3: A write to offset 4+k (k = 0..3) loads pending latch k with the code {data[3:0], staging[7:0]}, so code bits 11:8 come from data bits 3:0. Data bits 7:4 are ignored. Example: code 1776 is written as low 0xF0 and then high 0x06.
- R4: Writes never change any output latch. The outputs change only on an update.
- R5: A read at any offset from 4 to 7 copies all four pending latches to the output latches on the same edge. The new outputs are visible after that edge.
- R6: On an update, a channel with no new high write since the previous update keeps its output value.
- R7: Writes to offsets other than 1 and 4..7 change no latch. Reads from offsets outside 4..7 cause no update.
- R8: An access with both read and write asserted is treated as a read only. Its write data is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| busAddr | input | 4 | Register offset |
| busWrData | input | 8 | Write data byte |
| busWr | input | 1 | Write strobe, one access per cycle |
| busRd | input | 1 | Read strobe (update trigger at offsets 4..7) |
| dacCodes | output | 48 | Output codes, channel k at bits [12k+11:12k] |

## Verification
The bench builds the block with its default values: four channels, 12-bit codes, an 8-bit bus and a 4-bit address. The 4-bit address spans all sixteen offsets, so random traffic reaches the decoded offsets, the unused offsets above and below them, and the case where read and write are asserted together. With 12-bit codes, the bench can write 4095 directly and can put junk in the upper nibble of a high write to check that it is dropped.

// File: rtl/dac_quad_pkg.sv
package dac_quad_pkg;
  localparam int SEL_W = 8;

  typedef struct packed {
    logic             lowWr;
    logic             hiWr;
    logic             upd;
    logic [SEL_W-1:0] chSel;
  } dacStrobe_t;
endpackage

// File: rtl/dac_quad_ctrl.sv
module dac_quad_ctrl
  import dac_quad_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int NUM_CH   = 4,
  parameter int LOW_ADDR = 1,
  parameter int HI_BASE  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  output dacStrobe_t        strobe
);
  localparam logic [ADDR_W:0] LOW_A  = (ADDR_W+1)'(LOW_ADDR);
  localparam logic [ADDR_W:0] HI_A   = (ADDR_W+1)'(HI_BASE);
  localparam logic [ADDR_W:0] HI_END = (ADDR_W+1)'(HI_BASE + NUM_CH);

  logic [ADDR_W:0] addrExt;
  logic            inHi;
  logic            inLow;
  logic            wrOnly;

  assign addrExt = {1'b0, busAddr};
  assign inHi    = (addrExt >= HI_A) && (addrExt < HI_END);
  assign inLow   = (addrExt == LOW_A);
  assign wrOnly  = busWr && !busRd;

  always_comb begin
    strobe       = '0;
    strobe.upd   = busRd && inHi;
    strobe.lowWr = wrOnly && inLow;
    strobe.hiWr  = wrOnly && inHi;
    strobe.chSel = SEL_W'(addrExt - HI_A);
  end

  // R8: read wins over a simultaneous write
  a_r8_read_priority: assert property (@(posedge clk) disable iff (rst)
    (busWr && busRd) |-> !(strobe.lowWr || strobe.hiWr));

  // R7: at most one action per access
  a_r7_single_action: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobe.lowWr, strobe.hiWr, strobe.upd}));

  // R7: nothing fires for an address outside the decoded windows
  a_r7_idle_addr: assert property (@(posedge clk) disable iff (rst)
    (!inHi && !inLow) |-> !(strobe.lowWr || strobe.hiWr || strobe.upd));
endmodule

// File: rtl/dac_quad_chan.sv
module dac_quad_chan #(
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              loadEn,
  input  logic              updEn,
  input  logic [CODE_W-1:0] loadCode,
  output logic [CODE_W-1:0] outCode
);
  logic [CODE_W-1:0] pendCode;

  always_ff @(posedge clk) begin
    if (rst) begin
      pendCode <= '0;
      outCode  <= '0;
    end else begin
      if (loadEn) pendCode <= loadCode;
      if (updEn)  outCode  <= pendCode;
    end
  end

  // R1: reset leaves the output at zero
  a_r1_reset_zero: assert property (@(posedge clk)
    rst |=> (outCode == '0));

  // R4: without an update the output holds
  a_r4_out_hold: assert property (@(posedge clk) disable iff (rst)
    !updEn |=> $stable(outCode));

  // R5: an update presents the pending value from before the edge
  a_r5_update_copy: assert property (@(posedge clk) disable iff (rst)
    updEn |=> (outCode == $past(pendCode)));

  // R6: with no load the pending latch keeps its value
  a_r6_pend_keep: assert property (@(posedge clk) disable iff (rst)
    !loadEn |=> $stable(pendCode));
endmodule

// File: rtl/dac_quad_datapath.sv
module dac_quad_datapath
  import dac_quad_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CODE_W = 12,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  dacStrobe_t               strobe,
  input  logic [DATA_W-1:0]        wrData,
  output logic [NUM_CH*CODE_W-1:0] codes
);
  localparam int HI_W = CODE_W - DATA_W;

  logic [DATA_W-1:0] stageByte;
  logic [CODE_W-1:0] joinedCode;
  logic              unusedHiBits;

  assign joinedCode   = {wrData[HI_W-1:0], stageByte};
  assign unusedHiBits = ^wrData[DATA_W-1:HI_W];

  always_ff @(posedge clk) begin
    if (rst)               stageByte <= '0;
    else if (strobe.lowWr) stageByte <= wrData;
  end

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    logic chLoad;
    assign chLoad = strobe.hiWr && (strobe.chSel == SEL_W'(k));

    dac_quad_chan #(.CODE_W(CODE_W)) u_chan (
      .clk     (clk),
      .rst     (rst),
      .loadEn  (chLoad),
      .updEn   (strobe.upd),
      .loadCode(joinedCode),
      .outCode (codes[k*CODE_W +: CODE_W])
    );
  end

  // R2: the staging byte changes only on a low write
  a_r2_stage_hold: assert property (@(posedge clk) disable iff (rst)
    !strobe.lowWr |=> $stable(stageByte));

  // R2: a low write captures the bus byte
  a_r2_stage_load: assert property (@(posedge clk) disable iff (rst)
    strobe.lowWr |=> (stageByte == $past(wrData)));
endmodule

// File: rtl/dac_quad_latch.sv
module dac_quad_latch #(
  parameter int NUM_CH   = 4,
  parameter int CODE_W   = 12,
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 4,
  parameter int LOW_ADDR = 1,
  parameter int HI_BASE  = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        busAddr,
  input  logic [DATA_W-1:0]        busWrData,
  input  logic                     busWr,
  input  logic                     busRd,
  output logic [NUM_CH*CODE_W-1:0] dacCodes
);
  dac_quad_pkg::dacStrobe_t strobe;

  dac_quad_ctrl #(
    .ADDR_W(ADDR_W), .NUM_CH(NUM_CH),
    .LOW_ADDR(LOW_ADDR), .HI_BASE(HI_BASE)
  ) u_ctrl (
    .clk(clk), .rst(rst), .busAddr(busAddr),
    .busWr(busWr), .busRd(busRd), .strobe(strobe)
  );

  dac_quad_datapath #(
    .NUM_CH(NUM_CH), .CODE_W(CODE_W), .DATA_W(DATA_W)
  ) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe),
    .wrData(busWrData), .codes(dacCodes)
  );

  // R4: a write-only access never moves the outputs
  a_r4_write_no_out: assert property (@(posedge clk) disable iff (rst)
    (busWr && !busRd) |=> $stable(dacCodes));
endmodule

// File: tb/dac_quad_latch_tb.sv
module dac_quad_latch_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  busAddr;
  logic [7:0]  busWrData;
  logic        busWr;
  logic        busRd;
  logic [47:0] dacCodes;

  int total = 0;
  int bad   = 0;

  logic [7:0]  mStage;
  logic [11:0] mPend [4];
  logic [11:0] mOut  [4];

  always #10 clk = ~clk;

  dac_quad_latch u_dut (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busWrData(busWrData),
    .busWr(busWr), .busRd(busRd), .dacCodes(dacCodes)
  );

  function automatic logic [11:0] joinCode(logic [7:0] hi, logic [7:0] lo);
    return {hi[3:0], lo};
  endfunction

  function automatic bit isHi(logic [3:0] a);
    return (a >= 4'd4) && (a <= 4'd7);
  endfunction

  task automatic checkOuts(string tag);
    for (int k = 0; k < 4; k++) begin
      logic [11:0] got;
      got = dacCodes[k*12 +: 12];
      total++;
      if (got !== mOut[k]) begin
        bad++;
        $display("FAIL %s ch%0d actual=%0d expected=%0d", tag, k, got, mOut[k]);
      end
    end
  endtask

  task automatic access(bit wr, bit rd, logic [3:0] a, logic [7:0] d, string tag);
    @(negedge clk);
    busWr = wr; busRd = rd; busAddr = a; busWrData = d;
    @(negedge clk);
    busWr = 1'b0; busRd = 1'b0;
    if (rd) begin
      if (isHi(a)) for (int k = 0; k < 4; k++) mOut[k] = mPend[k];
    end else if (wr) begin
      if (a == 4'd1) mStage = d;
      else if (isHi(a)) mPend[a-4] = joinCode(d, mStage);
    end
    checkOuts(tag);
  endtask

  initial begin
    #(20 * 200000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'h5EED1234);
    rst = 1'b1; busWr = 0; busRd = 0; busAddr = 0; busWrData = 0;
    mStage = 0;
    for (int k = 0; k < 4; k++) begin mPend[k] = 0; mOut[k] = 0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    checkOuts("R1 reset");
    access(0, 1, 4'd5, 8'h00, "R1 update after reset");
    access(1, 0, 4'd6, 8'h03, "R1 hi write with zero staging");
    access(0, 1, 4'd6, 8'h00, "R1 update shows 0x300");

    access(1, 0, 4'd1, 8'hF0, "R2 low 0xF0");
    access(1, 0, 4'd4, 8'h06, "R4 hi write holds outputs");
    access(0, 1, 4'd7, 8'h00, "R5 update gives 1776");
    total++;
    if (dacCodes[11:0] !== 12'd1776) begin
      bad++;
      $display("FAIL R3 actual=%0d expected=1776", dacCodes[11:0]);
    end

    access(1, 0, 4'd1, 8'hFF, "R2 low 0xFF");
    access(1, 0, 4'd5, 8'hAF, "R3 junk upper nibble");
    access(0, 1, 4'd4, 8'h00, "R3 update gives 4095");
    total++;
    if (dacCodes[23:12] !== 12'hFFF) begin
      bad++;
      $display("FAIL R3 actual=%0d expected=4095", dacCodes[23:12]);
    end

    access(1, 0, 4'd1, 8'h5A, "R2 shared low");
    access(1, 0, 4'd6, 8'h01, "R2 ch2 from shared low");
    access(1, 0, 4'd7, 8'h02, "R2 ch3 from shared low");
    access(0, 1, 4'd5, 8'h00, "R2 update 0x15A 0x25A");
    access(0, 1, 4'd6, 8'h00, "R6 repeat update keeps values");

    access(1, 0, 4'd1, 8'h11, "R7 low 0x11");
    access(1, 0, 4'd2, 8'h99, "R7 write offset 2 ignored");
    access(1, 0, 4'd0, 8'h77, "R7 write offset 0 ignored");
    access(1, 0, 4'd12, 8'h0C, "R7 write offset 12 ignored");
    access(1, 0, 4'd4, 8'h00, "R7 ch0 load 0x011");
    access(0, 1, 4'd0, 8'h00, "R7 read offset 0 no update");
    access(0, 1, 4'd8, 8'h00, "R7 read offset 8 no update");
    access(0, 1, 4'd1, 8'h00, "R7 read offset 1 no update");
    access(0, 1, 4'd4, 8'h00, "R7 update shows 0x011");

    access(1, 0, 4'd1, 8'h33, "R8 low 0x33");
    access(1, 1, 4'd4, 8'h0E, "R8 read+write updates only");
    access(0, 1, 4'd4, 8'h00, "R8 ch0 unchanged");

    for (int i = 0; i < 600; i++) begin
      logic [3:0] a;
      bit wr, rd;
      int sel;
      sel = int'($urandom_range(0, 9));
      a   = 4'($urandom_range(0, 15));
      if (sel < 3) a = 4'd1;
      else if (sel < 7) a = 4'(4 + $urandom_range(0, 3));
      wr = ($urandom_range(0, 3) != 0);
      rd = ($urandom_range(0, 3) == 0);
      access(wr, rd, a, 8'($urandom), "R5/R6 random traffic");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule